// File: doc/BRIEF.md
# Shared interrupt source router

The router takes a set of level-sensitive interrupt sources and steers each one to a single CPU interrupt pin on a single virtual processor. Every source carries four pieces of state: a pending bit that tracks its input level, an enable bit, a pin number and a processor assignment. The output is a flat vector with one level per (processor, pin) pair. Each level is the OR of every source that is enabled, pending and routed to that pair.

Software reaches the state through a word-wide register port with separate write and read strobes. The pending and enable bits are read one bit per source, 32 sources to a word. Enables change only through separate write-one-to-set and write-one-to-clear words, so two agents can change different sources without a read-modify-write. The pin map takes one word per source. The processor map takes an eight-word slot per source: it is written as a bit mask and kept as an index. A software level register drives any source's pending bit directly.

Top module: `sirq_router`

## Requirements
- R1: A source's pending bit takes the new level of its input in the cycle that input changes, whether the source is enabled or not. Inputs are sampled every clock, and with no change and no software level write the pending bit holds.
- R2: Output bit `v*NUM_PIN + p` is 1 exactly when at least one source is enabled, pending, assigned to processor `v` and mapped to pin `p`. It is registered and reflects a register write or an input change from the clock edge that takes that event.
- R3: The pending window at byte offset 0x000 + 4w and the enable window at 0x100 + 4w both return source 32w+b in bit b.
- R4: Writing to 0x200 + 4w sets the enable of source 32w+b for every 1 in bit b. Writing to 0x300 + 4w clears it. A 0 bit leaves that enable as it was.
- R5: The pin map of source s sits at byte 0x1000 + 4s and holds a route flag in bit 31 and a pin number in bits 5:0. A write with bits 5:0 above NUM_PIN-1 changes nothing. A read returns the flag in bit 31, the pin in bits 5:0 and zeros elsewhere.
- R6: The processor map of source s is the 32-byte slot at 0x2000 + 32s. A nonzero write stores the index of its lowest set bit. A write of zero leaves the source unassigned. A write whose lowest set bit is at or above NUM_VP changes nothing. A read returns a one-hot mask, or 0 when the source is unassigned.
- R7: A write to byte 0x400 sets the pending bit of the source numbered in bits 30:0 to the value of bit 31. A source number at or above N is ignored. If the same source's input changes in the same cycle, the software value wins.
- R8: After reset all enables, pending bits and outputs are 0. Every pin map reads 0x8000_0000 and every processor map is unassigned.
- R9: A write that names a source index at or above N has no effect. A read of such an index returns 0.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N | Source levels, synchronous to `clk` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_VP*NUM_PIN | Pin levels, bit `v*NUM_PIN + p` for processor v, pin p |

## Verification
The bench builds the router with N = 16, NUM_VP = 4 and NUM_PIN = 6. With these values source index 16 is past the end and processor bit 4 is past the last processor, so the rejection paths take only a few writes. Pin value 6 is the first invalid pin. A second enable word lies wholly outside the sources, which exercises the zero read-back of a window with no sources in it. Four processors and six pins give 24 output bits, enough to show two sources sharing one pin while another source drives a different processor.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Word addresses (byte offset / 4) of the register windows
  localparam int unsigned A_PEND    = 'h000;
  localparam int unsigned A_EN      = 'h040;
  localparam int unsigned A_SET     = 'h080;
  localparam int unsigned A_CLR     = 'h0C0;
  localparam int unsigned A_LEVEL   = 'h100;
  localparam int unsigned A_PIN     = 'h400;
  // Processor map slots, 8 words each: slot number = word address / 8
  localparam int unsigned A_VP_SLOT = 'h100;

  localparam int unsigned PIN_FIELD_W = 6;

  // Index of the lowest set bit, 0 when none is set
  function automatic logic [5:0] lowest_set(input logic [31:0] d);
    lowest_set = '0;
    for (int i = 31; i >= 0; i--) begin
      if (d[i]) lowest_set = 6'(i);
    end
  endfunction

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int N       = 64,
  parameter int NUM_VP  = 2,
  parameter int NUM_PIN = 6,
  parameter int ADDR_W  = 12,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [N-1:0]      set_m,
  output logic [N-1:0]      clr_m,
  output logic [N-1:0]      lvl_hit,
  output logic              lvl_val,
  output logic [N-1:0]      pin_hit,
  output logic [PW-1:0]     pin_val,
  output logic              flag_val,
  output logic [N-1:0]      vp_hit,
  output logic              vp_map,
  output logic [VW-1:0]     vp_idx
);

  localparam logic [ADDR_W-1:0] LEVEL_A = ADDR_W'(A_LEVEL);

  logic [5:0] low;
  logic       pin_ok;
  logic       vp_ok;
  logic       lvl_sel;

  assign low      = lowest_set(wdata);
  assign pin_ok   = int'(wdata[PIN_FIELD_W-1:0]) < NUM_PIN;
  assign vp_map   = |wdata;
  assign vp_ok    = !vp_map || (int'(low) < NUM_VP);
  assign vp_idx   = low[VW-1:0];
  assign pin_val  = wdata[PW-1:0];
  assign flag_val = wdata[31];
  assign lvl_val  = wdata[31];
  assign lvl_sel  = wr && (addr == LEVEL_A);

  for (genvar s = 0; s < N; s++) begin : g_src
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(A_SET + s / 32);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(A_CLR + s / 32);
    localparam logic [ADDR_W-1:0] PIN_A = ADDR_W'(A_PIN + s);
    localparam logic [ADDR_W-4:0] VP_S  = (ADDR_W-3)'(A_VP_SLOT + s);

    assign set_m[s]   = wr && (addr == SET_A) && wdata[s % 32];
    assign clr_m[s]   = wr && (addr == CLR_A) && wdata[s % 32];
    assign pin_hit[s] = wr && (addr == PIN_A) && pin_ok;
    assign vp_hit[s]  = wr && (addr[ADDR_W-1:3] == VP_S) && vp_ok;
    assign lvl_hit[s] = lvl_sel && (wdata[30:0] == 31'(s));
  end

endmodule

// File: rtl/sirq_src_state.sv
module sirq_src_state #(
  parameter int N       = 64,
  parameter int NUM_VP  = 2,
  parameter int NUM_PIN = 6,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    src_in,
  input  logic [N-1:0]    set_m,
  input  logic [N-1:0]    clr_m,
  input  logic [N-1:0]    lvl_hit,
  input  logic            lvl_val,
  input  logic [N-1:0]    pin_hit,
  input  logic [PW-1:0]   pin_val,
  input  logic            flag_val,
  input  logic [N-1:0]    vp_hit,
  input  logic            vp_map,
  input  logic [VW-1:0]   vp_idx,
  output logic [N-1:0]    pend_q,
  output logic [N-1:0]    en_q,
  output logic [N*PW-1:0] pin_q,
  output logic [N-1:0]    flag_q,
  output logic [N-1:0]    vpok_q,
  output logic [N*VW-1:0] vpi_q,
  output logic [N-1:0]    pend_n,
  output logic [N-1:0]    en_n,
  output logic [N*PW-1:0] pin_n,
  output logic [N-1:0]    vpok_n,
  output logic [N*VW-1:0] vpi_n
);

  for (genvar s = 0; s < N; s++) begin : g_src
    logic          src_r;
    logic          pend_r;
    logic          en_r;
    logic [PW-1:0] pin_r;
    logic          flag_r;
    logic          vpok_r;
    logic [VW-1:0] vpi_r;
    logic          flag_nx;

    // software level write takes priority over an input change
    assign pend_n[s] = lvl_hit[s] ? lvl_val :
                       (src_in[s] != src_r) ? src_in[s] : pend_r;
    assign en_n[s]   = set_m[s] ? 1'b1 : (clr_m[s] ? 1'b0 : en_r);
    assign pin_n[s*PW +: PW] = pin_hit[s] ? pin_val : pin_r;
    assign flag_nx   = pin_hit[s] ? flag_val : flag_r;
    assign vpok_n[s] = vp_hit[s] ? vp_map : vpok_r;
    assign vpi_n[s*VW +: VW] = vp_hit[s] ? vp_idx : vpi_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        src_r  <= 1'b0;
        pend_r <= 1'b0;
        en_r   <= 1'b0;
        pin_r  <= '0;
        flag_r <= 1'b1;
        vpok_r <= 1'b0;
        vpi_r  <= '0;
      end else begin
        src_r  <= src_in[s];
        pend_r <= pend_n[s];
        en_r   <= en_n[s];
        pin_r  <= pin_n[s*PW +: PW];
        flag_r <= flag_nx;
        vpok_r <= vpok_n[s];
        vpi_r  <= vpi_n[s*VW +: VW];
      end
    end

    assign pend_q[s]         = pend_r;
    assign en_q[s]           = en_r;
    assign pin_q[s*PW +: PW] = pin_r;
    assign flag_q[s]         = flag_r;
    assign vpok_q[s]         = vpok_r;
    assign vpi_q[s*VW +: VW] = vpi_r;
  end

endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int N       = 64,
  parameter int NUM_VP  = 2,
  parameter int NUM_PIN = 6,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int OW = NUM_VP * NUM_PIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    pend_n,
  input  logic [N-1:0]    en_n,
  input  logic [N*PW-1:0] pin_n,
  input  logic [N-1:0]    vpok_n,
  input  logic [N*VW-1:0] vpi_n,
  output logic [OW-1:0]   irq_q
);

  logic [N-1:0]  live;
  logic [OW-1:0] hit_v;

  assign live = pend_n & en_n & vpok_n;

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic h;
      always_comb begin
        h = 1'b0;
        for (int s = 0; s < N; s++) begin
          if (live[s] && (vpi_n[s*VW +: VW] == VW'(v)) &&
              (pin_n[s*PW +: PW] == PW'(p)))
            h = 1'b1;
        end
      end
      assign hit_v[v*NUM_PIN + p] = h;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= hit_v;
  end

endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int N       = 64,
  parameter int NUM_VP  = 2,
  parameter int NUM_PIN = 6,
  parameter int ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              src_in,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic [NUM_VP*NUM_PIN-1:0] irq_out
);

  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;

  logic [N-1:0]    set_m, clr_m, lvl_hit, pin_hit, vp_hit;
  logic            lvl_val, flag_val, vp_map;
  logic [PW-1:0]   pin_val;
  logic [VW-1:0]   vp_idx;
  logic [N-1:0]    pend_q, en_q, flag_q, vpok_q;
  logic [N*PW-1:0] pin_q, pin_n;
  logic [N*VW-1:0] vpi_q, vpi_n;
  logic [N-1:0]    pend_n, en_n, vpok_n;
  logic [31:0]     rd_word;

  sirq_decode #(.N(N), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .ADDR_W(ADDR_W)) i_dec (
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_m(set_m), .clr_m(clr_m), .lvl_hit(lvl_hit), .lvl_val(lvl_val),
    .pin_hit(pin_hit), .pin_val(pin_val), .flag_val(flag_val),
    .vp_hit(vp_hit), .vp_map(vp_map), .vp_idx(vp_idx)
  );

  sirq_src_state #(.N(N), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) i_state (
    .clk(clk), .rst(rst), .src_in(src_in),
    .set_m(set_m), .clr_m(clr_m), .lvl_hit(lvl_hit), .lvl_val(lvl_val),
    .pin_hit(pin_hit), .pin_val(pin_val), .flag_val(flag_val),
    .vp_hit(vp_hit), .vp_map(vp_map), .vp_idx(vp_idx),
    .pend_q(pend_q), .en_q(en_q), .pin_q(pin_q), .flag_q(flag_q),
    .vpok_q(vpok_q), .vpi_q(vpi_q),
    .pend_n(pend_n), .en_n(en_n), .pin_n(pin_n), .vpok_n(vpok_n), .vpi_n(vpi_n)
  );

  sirq_route #(.N(N), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) i_route (
    .clk(clk), .rst(rst),
    .pend_n(pend_n), .en_n(en_n), .pin_n(pin_n), .vpok_n(vpok_n), .vpi_n(vpi_n),
    .irq_q(irq_out)
  );

  // Read mux: sources beyond N have no decode entry and read as 0
  always_comb begin
    rd_word = '0;
    for (int s = 0; s < N; s++) begin
      if (reg_addr == ADDR_W'(A_PEND + s / 32)) rd_word[s % 32] = pend_q[s];
      if (reg_addr == ADDR_W'(A_EN + s / 32))   rd_word[s % 32] = en_q[s];
      if (reg_addr == ADDR_W'(A_PIN + s))
        rd_word = {flag_q[s], 25'd0, PIN_FIELD_W'(pin_q[s*PW +: PW])};
      if ((reg_addr[ADDR_W-1:3] == (ADDR_W-3)'(A_VP_SLOT + s)) && vpok_q[s])
        rd_word = 32'd1 << vpi_q[s*VW +: VW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk
  import sirq_pkg::*;
#(
  parameter int N       = 64,
  parameter int NUM_VP  = 2,
  parameter int NUM_PIN = 6,
  parameter int ADDR_W  = 12,
  localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int OW = NUM_VP * NUM_PIN
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    src_in,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]     reg_rdata,
  input logic [OW-1:0]   irq_out,
  input logic [N-1:0]    pend_q,
  input logic [N-1:0]    en_q,
  input logic [N*PW-1:0] pin_q,
  input logic [N-1:0]    vpok_q,
  input logic [N*VW-1:0] vpi_q
);

  logic [N-1:0]  prev_in;
  logic [N-1:0]  chg;
  logic [OW-1:0] want;
  logic          vp_rd;

  always_ff @(posedge clk) begin
    if (rst) prev_in <= '0;
    else     prev_in <= src_in;
  end
  assign chg   = src_in ^ prev_in;
  assign vp_rd = reg_rd && (reg_addr >= ADDR_W'(A_VP_SLOT * 8));

  always_comb begin
    want = '0;
    for (int s = 0; s < N; s++) begin
      if (pend_q[s] && en_q[s] && vpok_q[s])
        want[int'(vpi_q[s*VW +: VW]) * NUM_PIN + int'(pin_q[s*PW +: PW])] = 1'b1;
    end
  end

  p_pend_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> (((pend_q ^ $past(src_in)) & $past(chg)) == '0));

  p_pend_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && (chg == '0)) |=> $stable(pend_q));

  p_pin_level_r2: assert property (@(posedge clk) disable iff (rst)
    irq_out == want);

  p_en_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(en_q));

  p_maps_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(pin_q) && $stable(vpok_q) && $stable(vpi_q)));

  p_vp_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    vp_rd |=> $onehot0(reg_rdata));

endmodule

bind sirq_router sirq_router_chk #(
  .N(N), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .pend_q(pend_q), .en_q(en_q), .pin_q(pin_q), .vpok_q(vpok_q), .vpi_q(vpi_q)
);

// File: tb/test_sirq_router.sv
module test_sirq_router;
  localparam int N  = 16;
  localparam int NV = 4;
  localparam int NP = 6;
  localparam int AW = 12;
  localparam int OW = NV * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_in = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [OW-1:0] irq_out;

  always #5 clk = ~clk;

  sirq_router #(.N(N), .NUM_VP(NV), .NUM_PIN(NP), .ADDR_W(AW)) i_sirq_router (
    .clk(clk), .rst(rst), .src_in(src_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model of routing state
  bit en_m[N];
  bit pend_m[N];
  bit vpok_m[N];
  int pin_m[N];
  int vpi_m[N];

  function automatic logic [OW-1:0] exp_irq();
    logic [OW-1:0] e = '0;
    for (int s = 0; s < N; s++)
      if (en_m[s] && pend_m[s] && vpok_m[s]) e[vpi_m[s] * NP + pin_m[s]] = 1'b1;
    return e;
  endfunction

  // monitor: compares read data the cycle after each read strobe
  logic rd_pend = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
      rd_pend = reg_rd;
    end
  end

  task automatic wr(input int byte_a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = AW'(byte_a / 4); reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int byte_a, input logic [31:0] e, input string t);
    @(posedge clk); #2;
    reg_rd = 1'b1; reg_addr = AW'(byte_a / 4);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  task automatic drv_src(input logic [N-1:0] v);
    @(posedge clk); #2;
    for (int s = 0; s < N; s++) if (v[s] != src_in[s]) pend_m[s] = v[s];
    src_in = v;
    @(posedge clk); #2;
  endtask

  task automatic chk_irq(input string t);
    @(negedge clk);
    n_cmp++;
    if (irq_out !== exp_irq()) begin
      n_bad++;
      $display("FAIL %s: irq_out actual %h expected %h", t, irq_out, exp_irq());
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      en_m[s] = 0; pend_m[s] = 0; vpok_m[s] = 0; pin_m[s] = 0; vpi_m[s] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R8 reset state
    chk_irq("R8 outputs low");
    rd('h000, 32'h0, "R8 pending clear");
    rd('h100, 32'h0, "R8 enables clear");
    rd('h1000 + 4*3, 32'h8000_0000, "R8 pin map default");
    rd('h2000 + 32*3, 32'h0, "R8 processor map unassigned");

    // R1 pending follows input while disabled
    drv_src(16'h0005);
    rd('h000, 32'h5, "R1 pending while disabled");
    chk_irq("R2 disabled sources silent");

    // R5 / R6 map programming
    wr('h1000, 32'h8000_0002); pin_m[0] = 2;
    wr('h2000, 32'h2);         vpok_m[0] = 1; vpi_m[0] = 1;
    wr('h1008, 32'h5);         pin_m[2] = 5;
    wr('h2040, 32'hC);         vpok_m[2] = 1; vpi_m[2] = 2;
    rd('h2040, 32'h4, "R6 lowest set bit kept");
    rd('h1008, 32'h5, "R5 pin and cleared flag");
    wr('h1000, 32'h6);
    rd('h1000, 32'h8000_0002, "R5 pin above range rejected");
    chk_irq("R2 mapped but disabled");

    // R4 set, R2 routing, R3 window
    wr('h200, 32'h1); en_m[0] = 1;
    chk_irq("R2 enable routes source 0");
    wr('h200, 32'h4); en_m[2] = 1;
    chk_irq("R4 set source 2");
    rd('h100, 32'h5, "R3 enable window bits");
    wr('h300, 32'h0);
    chk_irq("R4 zero clear bits no effect");
    rd('h100, 32'h5, "R4 enables kept");
    wr('h300, 32'h1); en_m[0] = 0;
    chk_irq("R4 clear source 0");
    rd('h100, 32'h4, "R4 enable after clear");

    // R1 level drops
    drv_src(16'h0004);
    rd('h000, 32'h4, "R1 falls while disabled");
    drv_src(16'h0000);
    chk_irq("R1 level drop clears pin");

    // R7 software level and R2 OR of sources
    wr('h1004, 32'h2); pin_m[1] = 2;
    wr('h2020, 32'h2); vpok_m[1] = 1; vpi_m[1] = 1;
    wr('h200, 32'h3);  en_m[0] = 1; en_m[1] = 1;
    wr('h400, 32'h8000_0001); pend_m[1] = 1;
    chk_irq("R7 software level drives pin");
    wr('h400, 32'h8000_0010);
    rd('h000, 32'h2, "R7 source beyond N ignored");
    drv_src(16'h0001);
    wr('h400, 32'h0000_0001); pend_m[1] = 0;
    chk_irq("R2 OR keeps pin with one source");

    // R7 software write wins over same-cycle input change
    @(posedge clk); #2;
    src_in = 16'h0009;
    reg_wr = 1'b1; reg_addr = AW'('h400 / 4); reg_wdata = 32'h0000_0003;
    @(posedge clk); #2;
    reg_wr = 1'b0; pend_m[3] = 0;
    rd('h000, 32'h1, "R7 software write wins");

    // R9 out-of-range indices
    wr('h1000 + 4*16, 32'h1);
    rd('h1000 + 4*16, 32'h0, "R9 pin map beyond N");
    wr('h2000 + 32*16, 32'h1);
    rd('h2000 + 32*16, 32'h0, "R9 processor map beyond N");
    wr('h204, 32'hFFFF_FFFF);
    rd('h104, 32'h0, "R9 enable word beyond N");
    rd('h100, 32'h7, "R9 in-range enables untouched");

    // R6 rejection and unassign
    wr('h2000, 32'h10);
    rd('h2000, 32'h2, "R6 processor above range rejected");
    wr('h2000, 32'h0); vpok_m[0] = 0;
    rd('h2000, 32'h0, "R6 zero unassigns");
    chk_irq("R2 unassigned source silent");

    // R10 back-to-back reads, each one cycle later
    rd('h000, 32'h1, "R10 read pending");
    rd('h100, 32'h7, "R10 read enables");
    rd('h2040, 32'h4, "R10 read processor map");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: reads left unanswered actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule